// File: doc/BRIEF.md
# Eight-Channel External Interrupt Sense Controller

The block watches eight external interrupt pins. Each pin gets a 2-bit sense code that picks one of four trigger conditions: held low, any change, falling edge or rising edge. Each pin passes through a two-stage synchronizer before detection. For the three edge-type codes, a detected event sets a per-channel flag that stays set until it is cleared. For the held-low code, no flag is kept. Instead the pin state itself forms the request for as long as the pin stays low.

Software reaches three registers through a strobed read/write port: sense codes, channel mask and event flags. A flag is cleared in one of two ways: by writing a 1 to its bit, or by the interrupt acknowledge that names its channel. The outgoing request is the lowest-numbered channel that is both requesting and unmasked, and it is gated by a global enable. The request is presented as a valid bit plus a 3-bit channel index.

The safe way to reconfigure a channel is:
1. Clear its mask bit.
2. Change its sense code.
3. Clear its flag by writing a 1.
4. Set the mask bit again.

Top module: `eirq_top`

## Requirements
- R1: The sense register sits at address 0, with channel i in bits 2i+1:2i. Its codes are: 00 held low, 01 any change (both directions), 10 falling edge only, 11 rising edge only. An edge of the direction not selected leaves the flag clear.
- R2: The mask register sits at address 1, with channel i in bit i. A channel whose mask bit is 0 never drives irqValid.
- R3: A pin change that matches an edge-type code sets flag bit i (flag register at address 2, bit i). The flag is visible on the third rising clock edge after the pin changes, not earlier. irqValid follows in the same cycle when the channel is enabled.
- R4: Writing address 2 clears each flag bit whose write-data bit is 1. Bits written with 0 keep their value. An event arriving in the same cycle as a clear wins.
- R5: ackValid with ackIdx clears the flag of that channel only.
- R6: With code 00, the flag reads 0 from the cycle after the code takes effect. The request follows the synchronized pin: it asserts on the second clock edge after the pin falls and drops on the second clock edge after the pin rises. Acknowledge does not remove it.
- R7: irqValid is 0 whenever globalEn is 0. globalEn acts on irqValid without any register delay.
- R8: When several channels request, irqIdx gives the lowest-numbered one. irqIdx is 0 whenever irqValid is 0.
- R9: After reset the sense, mask and flag registers are 0 and irqValid is 0. rdData is 0 whenever rdEn is 0.
- R10: Flags latch while the channel is masked. The request appears in the cycle after the mask bit is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | External interrupt pins, asynchronous |
| globalEn | input | 1 | Global interrupt enable |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 sense, 1 mask, 2 flag |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational, zero-extended |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| ackIdx | input | 3 | Channel being acknowledged |
| irqValid | output | 1 | Request pending |
| irqIdx | output | 3 | Winning channel |

## Verification
The assertions assume that the pins are held steady for at least two clocks per level, so that each change passes the synchronizer as one clean step. They also assume that acknowledge names a channel index that exists. The stimulus changes pins only just after a clock edge and keeps each level for three or more cycles before expecting a result. Register writes and acknowledges are issued as single-cycle strobes that never overlap.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int NCH     = 8;
  localparam int SENSE_W = 2;
  localparam int IDX_W   = $clog2(NCH);
  localparam int DATA_W  = NCH * SENSE_W;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NCH-1:0] flagSet;
    logic [NCH-1:0] flagClr;
    logic           senseWr;
    logic           maskWr;
  } strobe_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] doutPrev
);
  logic [W-1:0] pipe [STAGES+1];

  assign pipe[0] = din;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) pipe[s] <= IDLE;
      else       pipe[s] <= pipe[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doutPrev <= IDLE;
    else       doutPrev <= pipe[STAGES];
  end

  assign dout = pipe[STAGES];
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    pinNow,
  input  logic [NCH-1:0]    pinPrev,
  input  logic [DATA_W-1:0] senseQ,
  input  logic [NCH-1:0]    maskQ,
  input  logic [NCH-1:0]    flagQ,
  input  logic              globalEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wrBits,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIdx,
  output strobe_t           strobe,
  output logic              irqValid,
  output logic [IDX_W-1:0]  irqIdx
);
  logic [NCH-1:0] hitVec, clrVec, activeVec, lowVec;
  logic [IDX_W-1:0] encIdx;
  logic flagWr;

  assign flagWr = wrEn && (addr == ADDR_FLAG);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    senseMode_e mode;
    assign mode = senseMode_e'(senseQ[SENSE_W*i +: SENSE_W]);
    assign lowVec[i] = (mode == SENSE_LOW);

    always_comb begin
      unique case (mode)
        SENSE_ANY:  hitVec[i] = pinNow[i] ^ pinPrev[i];
        SENSE_FALL: hitVec[i] = pinPrev[i] & ~pinNow[i];
        SENSE_RISE: hitVec[i] = ~pinPrev[i] & pinNow[i];
        default:    hitVec[i] = 1'b0;
      endcase
    end

    assign clrVec[i]    = (flagWr && wrBits[i]) || (ackValid && ackIdx == IDX_W'(i));
    assign activeVec[i] = maskQ[i] & (lowVec[i] ? ~pinNow[i] : flagQ[i]);

    // R6: a held-low enabled pin must produce a request
    assert_low_req_R6: assert property (@(posedge clk) disable iff (!rstN)
      (lowVec[i] && maskQ[i] && !pinNow[i] && globalEn) |-> irqValid);
  end

  // fixed priority: lowest index wins
  always_comb begin
    encIdx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (activeVec[i]) encIdx = IDX_W'(i);
    end
  end

  assign irqValid = globalEn && (|activeVec);
  assign irqIdx   = irqValid ? encIdx : '0;

  assign strobe.flagSet = hitVec;
  assign strobe.flagClr = clrVec;
  assign strobe.senseWr = wrEn && (addr == ADDR_SENSE);
  assign strobe.maskWr  = wrEn && (addr == ADDR_MASK);

  logic [NCH-1:0] belowIdx;
  assign belowIdx = (NCH'(1) << irqIdx) - NCH'(1);

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> globalEn);
  assert_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> maskQ[irqIdx]);
  assert_priority_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((activeVec & belowIdx) == '0));
endmodule

// File: rtl/eirq_dpath.sv
module eirq_dpath
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] senseQ,
  output logic [NCH-1:0]    maskQ,
  output logic [NCH-1:0]    flagQ,
  output logic [DATA_W-1:0] rdData
);
  logic [NCH-1:0] flagNext, lowVec;

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    assign lowVec[i] = (senseQ[SENSE_W*i +: SENSE_W] == SENSE_LOW);
    // set beats clear; held-low channels keep no flag
    assign flagNext[i] = lowVec[i] ? 1'b0
                       : (strobe.flagSet[i] | (flagQ[i] & ~strobe.flagClr[i]));

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.flagSet[i] && !lowVec[i]) |=> flagQ[i]);
    // covers both software clear and acknowledge (R5)
    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.flagClr[i] && !strobe.flagSet[i]) |=> !flagQ[i]);
    assert_low_noflag_R6: assert property (@(posedge clk) disable iff (!rstN)
      lowVec[i] |=> !flagQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseQ <= '0;
      maskQ  <= '0;
      flagQ  <= '0;
    end else begin
      if (strobe.senseWr) senseQ <= wrData;
      if (strobe.maskWr)  maskQ  <= wrData[NCH-1:0];
      flagQ <= flagNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        ADDR_SENSE: rdData = senseQ;
        ADDR_MASK:  rdData = {{(DATA_W-NCH){1'b0}}, maskQ};
        ADDR_FLAG:  rdData = {{(DATA_W-NCH){1'b0}}, flagQ};
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/eirq_top.sv
module eirq_top
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    pinIn,
  input  logic              globalEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIdx,
  output logic              irqValid,
  output logic [IDX_W-1:0]  irqIdx
);
  logic [NCH-1:0]    pinNow, pinPrev, maskQ, flagQ;
  logic [DATA_W-1:0] senseQ;
  strobe_t           strobe;

  eirq_sync #(.W(NCH), .STAGES(2), .IDLE('1)) u_sync (
    .clk(clk), .rstN(rstN), .din(pinIn), .dout(pinNow), .doutPrev(pinPrev)
  );

  eirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinNow(pinNow), .pinPrev(pinPrev),
    .senseQ(senseQ), .maskQ(maskQ), .flagQ(flagQ), .globalEn(globalEn),
    .wrEn(wrEn), .addr(addr), .wrBits(wrData[NCH-1:0]),
    .ackValid(ackValid), .ackIdx(ackIdx), .strobe(strobe),
    .irqValid(irqValid), .irqIdx(irqIdx)
  );

  eirq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdEn(rdEn), .addr(addr), .senseQ(senseQ), .maskQ(maskQ),
    .flagQ(flagQ), .rdData(rdData)
  );
endmodule

// File: tb/eirq_top_test.sv
module eirq_top_test;
  import eirq_pkg::*;
  localparam int CLK_PERIOD = 20;

  logic clk, rstN, globalEn, wrEn, rdEn, ackValid, irqValid;
  logic [NCH-1:0] pinIn;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wrData, rdData;
  logic [IDX_W-1:0] ackIdx, irqIdx;

  eirq_top uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalEn(globalEn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .ackValid(ackValid), .ackIdx(ackIdx), .irqValid(irqValid), .irqIdx(irqIdx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    bit          isRead;
    logic [15:0] exp;
  } item_t;

  item_t sbQ[$];
  event  itemEv;
  int    errors = 0;
  int    checks = 0;
  bit    done = 0;

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(itemEv);
      #1;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it  = sbQ.pop_front();
        got = it.isRead ? rdData : {12'd0, irqValid, irqIdx};
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expIrq(string tag, bit v, int idx);
    item_t it;
    it.tag = tag; it.isRead = 1'b0; it.exp = {12'd0, v, 3'(idx)};
    sbQ.push_back(it);
    ->itemEv;
    #2;
  endtask

  task automatic expRead(string tag, logic [1:0] a, logic [15:0] e, bit en = 1'b1);
    item_t it;
    rdEn = en; addr = a;
    it.tag = tag; it.isRead = 1'b1; it.exp = e;
    sbQ.push_back(it);
    ->itemEv;
    #2;
    rdEn = 1'b0;
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic ack(int idx);
    ackIdx = 3'(idx); ackValid = 1'b1;
    tick(1);
    ackValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; pinIn = '1; globalEn = 1; wrEn = 0; rdEn = 0; addr = '0;
    wrData = '0; ackValid = 0; ackIdx = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick(1);

    // R9 reset state
    expIrq("R9 irq after reset", 0, 0);
    expRead("R9 sense reset", ADDR_SENSE, 16'h0000);
    expRead("R9 mask reset", ADDR_MASK, 16'h0000);
    expRead("R9 flag reset", ADDR_FLAG, 16'h0000);

    // R1 config: ch0 rise, ch1 fall, ch2 any, ch3 low, ch4 rise, ch5 fall, ch6 any, ch7 rise
    regWrite(ADDR_SENSE, 16'hDB1B);
    expRead("R1 sense readback", ADDR_SENSE, 16'hDB1B);
    expRead("R9 rdData zero when rdEn low", ADDR_SENSE, 16'h0000, 1'b0);

    // R3/R10 falling edge on ch1 while masked
    pinIn[1] = 1'b0;
    tick(2);
    expRead("R3 flag not yet set", ADDR_FLAG, 16'h0000);
    tick(1);
    expRead("R3 flag set on third edge", ADDR_FLAG, 16'h0002);
    expIrq("R2 masked channel no request", 0, 0);
    regWrite(ADDR_MASK, 16'h0002);
    expRead("R2 mask readback", ADDR_MASK, 16'h0002);
    expIrq("R10 request after unmask", 1, 1);

    // R7 global enable
    globalEn = 1'b0;
    expIrq("R7 gated by globalEn", 0, 0);
    globalEn = 1'b1;
    expIrq("R7 restored", 1, 1);

    // R5 acknowledge
    ack(1);
    expRead("R5 ack clears flag", ADDR_FLAG, 16'h0000);
    expIrq("R5 request gone", 0, 0);

    // R1 falling-only ignores rising
    pinIn[1] = 1'b1;
    tick(3);
    expRead("R1 fall mode ignores rise", ADDR_FLAG, 16'h0000);

    // R8 priority
    regWrite(ADDR_MASK, 16'h00FF);
    pinIn[0] = 1'b0;
    tick(3);
    expRead("R1 rise mode ignores fall", ADDR_FLAG, 16'h0000);
    expIrq("R6 low mode pin high no request", 0, 0);
    pinIn[0] = 1'b1; pinIn[2] = 1'b0; pinIn[5] = 1'b0;
    tick(2);
    expRead("R3 multi not yet", ADDR_FLAG, 16'h0000);
    tick(1);
    expRead("R3 multi flags", ADDR_FLAG, 16'h0025);
    expIrq("R8 lowest wins", 1, 0);
    ack(0);
    expIrq("R8 next after ack", 1, 2);
    expRead("R5 ack clears only its channel", ADDR_FLAG, 16'h0024);
    regWrite(ADDR_FLAG, 16'h0004);
    expRead("R4 write one clears", ADDR_FLAG, 16'h0020);
    expIrq("R8 remaining channel", 1, 5);
    regWrite(ADDR_FLAG, 16'h0000);
    expRead("R4 write zero no effect", ADDR_FLAG, 16'h0020);
    regWrite(ADDR_FLAG, 16'h0020);
    expRead("R4 last flag cleared", ADDR_FLAG, 16'h0000);
    expIrq("R4 no request left", 0, 0);

    // R6 held-low channel 3
    pinIn[3] = 1'b0;
    tick(1);
    expIrq("R6 not before second edge", 0, 0);
    tick(1);
    expIrq("R6 request on second edge", 1, 3);
    expRead("R6 flag reads zero", ADDR_FLAG, 16'h0000);
    tick(5);
    expIrq("R6 held while low", 1, 3);
    ack(3);
    expIrq("R6 ack does not remove", 1, 3);
    globalEn = 1'b0;
    expIrq("R7 gates level request", 0, 0);
    globalEn = 1'b1;
    pinIn[3] = 1'b1;
    tick(1);
    expIrq("R6 still low in sync", 1, 3);
    tick(1);
    expIrq("R6 drops after release", 0, 0);

    // R1 any-change catches rising too
    pinIn[2] = 1'b1;
    tick(3);
    expRead("R1 any mode rising", ADDR_FLAG, 16'h0004);
    expIrq("R1 any mode request", 1, 2);
    regWrite(ADDR_FLAG, 16'h0004);

    // R6 switching to low mode drops flag
    pinIn[4] = 1'b0;
    tick(3);
    pinIn[4] = 1'b1;
    tick(3);
    expRead("R3 rise flag ch4", ADDR_FLAG, 16'h0010);
    expIrq("R3 request ch4", 1, 4);
    regWrite(ADDR_SENSE, 16'hD81B);
    tick(1);
    expRead("R6 flag dropped in low mode", ADDR_FLAG, 16'h0000);
    expIrq("R6 no request pin high", 0, 0);
    expRead("R1 sense updated", ADDR_SENSE, 16'hD81B);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule